// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire (I2C) slave that gives a bus master access to a 256-byte memory. It samples the shared clock and data lines on the system clock and drives the data line only by pulling it low through an output enable. It answers to a 7-bit device address whose high nibble is fixed and whose low three bits come from strap inputs, so up to eight blocks can share one bus. An internal one-byte pointer selects the word that is read or written.

A write transaction gives the device address with the direction bit low, one word-address byte, and then up to eight data bytes. The data bytes are collected in a page buffer and reach the memory only after a STOP. This starts a self-timed write cycle of `WR_CYCLES` clocks. During that cycle the block ignores its own address, so a master can poll for the end of the cycle. A read transaction sends bytes from the pointer onwards. A random read is a write header that carries only the word address, followed by a repeated START and a read header.

FSM states: `ST_IDLE` (waits for START), `ST_DEVADDR` (shifts in the address byte), `ST_DEVACK` (drives the ACK for the address), `ST_WORDADDR` / `ST_WORDACK` (loads the pointer and ACKs it), `ST_WDATA` / `ST_WDACK` (buffers a data byte and ACKs it), `ST_RDATA` (shifts a byte out) and `ST_RDACK` (samples the master's ACK). The transitions are as follows. START moves from any state to `ST_DEVADDR`. STOP moves from any state to `ST_IDLE`. At the end of an address byte the FSM goes to `ST_DEVACK` on a match, or to `ST_IDLE` otherwise. After an address ACK it goes to `ST_RDATA` for a read, or to `ST_WORDADDR` for a write. After the word ACK it goes to `ST_WDATA`, and after a data ACK it goes back to `ST_WDATA`. `ST_RDATA` goes to `ST_RDACK` after eight bits. From `ST_RDACK` it returns to `ST_RDATA` on ACK, or goes to `ST_IDLE` on NACK.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block ACKs (pulls SDA low during the ninth clock) only for the address byte {1010, strap_i[2:0], R/W}. For any other address it leaves SDA released and ignores the bus until the next START.
- R2: A single data byte written to word address A and followed by STOP is stored at A and can be read back once the write cycle has ended.
- R3: In a write, each data byte increments only pointer bits [2:0], wrapping inside the 8-byte page while bits [7:3] stay fixed. Full pages and partial pages are both committed, and a byte that is not sent leaves its location unchanged.
- R4: After a STOP that ends a write with data bytes, the block stays busy for WR_CYCLES clocks and does not ACK its address during that time. Once the cycle has ended it ACKs again.
- R5: When wp_i is high at the STOP, the memory is not changed and no write cycle starts.
- R6: A random read (write header, word address, repeated START, read header) returns the byte at the loaded address.
- R7: In a read, each master ACK increments the pointer and sends the next byte. After address 255 the read continues from address 0.
- R8: A current-address read begins one past the last byte that was accessed.
- R9: After reset, after a NACK from the master, and after a STOP, the block leaves SDA released.
- R10: SDA is driven or released only while SCL is low. A START that arrives before the STOP of a write discards the buffered data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | When high, pulls the data line low |
| wp_i | input | 1 | Write protect; high blocks the memory commit |
| strap_i | input | 3 | Low three bits of the device address |

## Verification
A wrong FSM state shows up within one byte time as an ACK in the wrong slot, or as read data that is shifted by one bit. A wrong pointer or page buffer shows up only later, as a wrong byte on a read. The bench therefore keeps a model of the memory and pointer and reads back every region it writes. A busy flag that stays on too long, or ends too early, shows up on the next poll as an ACK that is missing or that comes too soon.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
    localparam int WORD_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int PAGE_BITS = 3;
    localparam int PAGE_LEN  = 1 << PAGE_BITS;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_WORDADDR, ST_WORDACK,
        ST_WDATA, ST_WDACK, ST_RDATA, ST_RDACK
    } slave_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
    logic scl_prev, sda_prev;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_chain[g] <= scl_i;
                    sda_chain[g] <= sda_i;
                end else begin
                    scl_chain[g] <= scl_chain[(g == 0) ? 0 : g-1];
                    sda_chain[g] <= sda_chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_chain[SYNC_STAGES-1];
    assign sda_lvl = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_write_timer.sv
module i2c_write_timer #(
    parameter int WR_CYCLES = 1250000,
    parameter int SLOTS     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    output logic                         busy,
    output logic                         slot_en,
    output logic [$clog2(SLOTS)-1:0]     slot
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WR_CYCLES - 1)) busy <= 1'b0;
        end
    end

    assign slot_en = busy && (cnt < CNT_W'(SLOTS));
    assign slot    = cnt[$clog2(SLOTS)-1:0];
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_eeprom_pkg::*;
#(
    parameter int WR_CYCLES   = 1250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       wp_i,
    input  logic [2:0] strap_i
);
    slave_state_t state, nxt;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [2:0]          bitcnt;
    logic                got;
    logic [WORD_W-1:0]   sh, tx;
    logic                rw, ack_r, pend;
    logic [ADDR_W-1:0]   ptr;
    logic [WORD_W-1:0]   pbuf [PAGE_LEN];
    logic [PAGE_LEN-1:0] mask;
    logic                busy, slot_en;
    logic [PAGE_BITS-1:0] slot;
    logic [WORD_W-1:0]   rd_data;
    logic                commit_go, mem_we, match, rx_state;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_write_timer #(.WR_CYCLES(WR_CYCLES), .SLOTS(PAGE_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(commit_go),
        .busy(busy), .slot_en(slot_en), .slot(slot)
    );

    assign mem_we = slot_en && mask[slot];

    i2c_byte_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk(clk), .we(mem_we), .waddr({ptr[ADDR_W-1:PAGE_BITS], slot}),
        .wdata(pbuf[slot]), .raddr(ptr), .rdata(rd_data)
    );

    assign match     = (sh[7:1] == {DEV_PREFIX, strap_i}) && !busy;
    assign commit_go = stop_det && pend && !wp_i;
    assign rx_state  = (state == ST_DEVADDR) || (state == ST_WORDADDR) || (state == ST_WDATA);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_IDLE;
            ST_DEVADDR:  if (scl_fall && got) nxt = match ? ST_DEVACK : ST_IDLE;
            ST_DEVACK:   if (scl_fall) nxt = rw ? ST_RDATA : ST_WORDADDR;
            ST_WORDADDR: if (scl_fall && got) nxt = ST_WORDACK;
            ST_WORDACK:  if (scl_fall) nxt = ST_WDATA;
            ST_WDATA:    if (scl_fall && got) nxt = ST_WDACK;
            ST_WDACK:    if (scl_fall) nxt = ST_WDATA;
            ST_RDATA:    if (scl_fall && bitcnt == 3'd7) nxt = ST_RDACK;
            ST_RDACK:    if (scl_fall) nxt = ack_r ? ST_RDATA : ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_DEVADDR;
        else if (stop_det) nxt = ST_IDLE;
    end

    // datapath: shifters, pointer, page buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0; got <= 1'b0; sh <= '0; tx <= '0;
            rw <= 1'b0; ack_r <= 1'b0; pend <= 1'b0; ptr <= '0; mask <= '0;
            for (int i = 0; i < PAGE_LEN; i++) pbuf[i] <= '0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
            got    <= 1'b0;
            pend   <= 1'b0;
        end else if (scl_rise) begin
            if (rx_state) begin
                sh     <= {sh[WORD_W-2:0], sda_lvl};
                bitcnt <= bitcnt + 3'd1;
                got    <= (bitcnt == 3'd7);
            end
            if (state == ST_RDACK) ack_r <= !sda_lvl;
        end else if (scl_fall) begin
            unique case (state)
                ST_DEVADDR:  if (got) begin rw <= sh[0]; got <= 1'b0; end
                ST_WORDADDR: if (got) begin ptr <= sh; mask <= '0; got <= 1'b0; end
                ST_WDATA: if (got) begin
                    pbuf[ptr[PAGE_BITS-1:0]] <= sh;
                    mask[ptr[PAGE_BITS-1:0]] <= 1'b1;
                    ptr[PAGE_BITS-1:0]       <= ptr[PAGE_BITS-1:0] + 1'b1;
                    pend <= 1'b1;
                    got  <= 1'b0;
                end
                ST_DEVACK: begin
                    bitcnt <= '0;
                    if (rw) begin tx <= rd_data; ptr <= ptr + 1'b1; end
                end
                ST_RDATA: begin
                    tx     <= {tx[WORD_W-2:0], 1'b0};
                    bitcnt <= bitcnt + 3'd1;
                end
                ST_RDACK: begin
                    bitcnt <= '0;
                    if (ack_r) begin tx <= rd_data; ptr <= ptr + 1'b1; end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEVACK, ST_WORDACK, ST_WDACK: sda_oe = 1'b1;
            ST_RDATA:                        sda_oe = ~tx[WORD_W-1];
            default:                         sda_oe = 1'b0;
        endcase
    end

    // SDA is only driven or released while SCL is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // a write cycle never starts while write protect was high at the STOP
    assert_wp_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

    // no address ACK while the write cycle runs
    assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVACK) |-> !busy);

    // the page being committed stays fixed during the cycle
    assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(ptr[ADDR_W-1:PAGE_BITS]));

    // the memory is written only inside a write cycle
    assert_we_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy && !$past(pend && !busy && !stop_det));
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
    localparam int WR = 200;
    localparam logic [7:0] AW = 8'hAA;
    localparam logic [7:0] AR = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_oe, sda_line;
    int   errors = 0, checks = 0;
    bit   done = 1'b0;

    logic [7:0] model [256];
    logic [7:0] bptr = 8'h00;
    logic [7:0] wbuf [8];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_q [$];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_slave #(.WR_CYCLES(WR)) u_i2c_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .wp_i(wp), .strap_i(3'b101)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b0; wt(4); sda_m = 1'b1; wt(4);
        scl = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl = 1'b0; wt(4);
    endtask

    task automatic bus_stop();
        scl = 1'b0; wt(4); sda_m = 1'b0; wt(4);
        scl = 1'b1; wt(8); sda_m = 1'b1; wt(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wt(4); sda_m = b[i]; wt(4); scl = 1'b1; wt(8); scl = 1'b0;
        end
        wt(1); sda_m = 1'b1; wt(7); scl = 1'b1; wt(4);
        acked = !sda_line;
        wt(4); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack);
        logic [7:0] b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wt(8); scl = 1'b1; wt(4);
            b = {b[6:0], sda_line};
            wt(4); scl = 1'b0;
        end
        obs_q.push_back(b);
        wt(4); sda_m = give_ack ? 1'b0 : 1'b1; wt(4);
        scl = 1'b1; wt(8); scl = 1'b0; wt(1); sda_m = 1'b1;
    endtask

    // driver side of the scoreboard
    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic poll(input bit want_ack, input string req);
        bit a;
        bus_start(); send_byte(AW, a); bus_stop();
        check(a == want_ack, req, a, want_ack);
    endtask

    task automatic write_seq(input logic [7:0] addr, input int n, input string req);
        bit a;
        logic [7:0] p = addr;
        bus_start();
        send_byte(AW, a); check(a, {req, " header ack"}, a, 1);
        send_byte(addr, a); check(a, {req, " word ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            if (!wp) model[p] = wbuf[i];
            p[2:0] = p[2:0] + 3'd1;
        end
        bus_stop();
        bptr = p;
    endtask

    task automatic read_rand(input logic [7:0] addr, input int n, input string req);
        bit a;
        bus_start(); send_byte(AW, a); send_byte(addr, a);
        bus_start(); send_byte(AR, a); check(a, {req, " read header ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            expect_byte(model[8'(addr + i)], req);
            recv_byte(i < n - 1);
        end
        bus_stop();
        bptr = 8'(addr + n);
        check(sda_oe == 1'b0, "R9 release after NACK and STOP", sda_oe, 0);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o, e;
                string t;
                o = obs_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                check(o == e, t, o, e);
            end
        end
    end

    initial begin
        wt(150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wt(5); rst_n = 1'b1; wt(5);
        check(sda_oe == 1'b0, "R9 released after reset", sda_oe, 0);

        // R1: foreign address stays silent
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check(!a, "R1 wrong address NACK", a, 0);

        // seed known contents across the array (page by page)
        for (int pg = 0; pg < 32; pg++) begin
            for (int i = 0; i < 8; i++) wbuf[i] = 8'(pg * 8 + i + 8'h01);
            write_seq(8'(pg * 8), 8, "R3 seed page");
            wt(WR + 20);
        end

        // R2 + R4: byte write, busy polling
        wbuf[0] = 8'h3C;
        write_seq(8'h10, 1, "R2 byte write");
        poll(1'b0, "R4 NACK while busy");
        wt(WR + 20);
        poll(1'b1, "R4 ACK after cycle");
        read_rand(8'h10, 1, "R6 random read");

        // R3: full page then partial page that wraps in the page
        for (int i = 0; i < 8; i++) wbuf[i] = 8'hB0 + 8'(i);
        write_seq(8'h08, 8, "R3 full page");
        wt(WR + 20);
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
        write_seq(8'h0E, 3, "R3 partial wrap");
        wt(WR + 20);
        read_rand(8'h08, 8, "R3 R7 page readback");

        // R8: current-address read continues after the last byte
        bus_start(); send_byte(AR, a);
        check(a, "R8 current read ack", a, 1);
        expect_byte(model[bptr], "R8 current read");
        recv_byte(1'b0); bus_stop();

        // R7: wrap from 255 to 0
        wbuf[0] = 8'h77; write_seq(8'hFF, 1, "R7 top byte"); wt(WR + 20);
        wbuf[0] = 8'h66; write_seq(8'h00, 1, "R7 bottom byte"); wt(WR + 20);
        read_rand(8'hFE, 3, "R7 wrap read");

        // R5: write protect
        wp = 1'b1;
        wbuf[0] = 8'h99; write_seq(8'h10, 1, "R5 protected write");
        poll(1'b1, "R5 no write cycle");
        wp = 1'b0;
        read_rand(8'h10, 1, "R5 unchanged");

        // R10: START before STOP discards buffered bytes
        bus_start(); send_byte(AW, a); send_byte(8'h20, a); send_byte(8'h5A, a);
        bus_start(); send_byte(AW, a); send_byte(8'h20, a);
        bus_start(); send_byte(AR, a);
        expect_byte(model[8'h20], "R10 aborted write discarded");
        recv_byte(1'b0); bus_stop();
        poll(1'b1, "R10 no cycle after abort");

        wt(50);
        check(exp_q.size() == 0 && obs_q.size() == 0, "scoreboard drained",
              obs_q.size(), exp_q.size());
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule